// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital core of a 12-bit successive-approximation converter. A falling edge on the active-low start input, while the chip-select input is low and the part is awake, begins one conversion. The controller clears its approximation register and offers a trial word to an external DAC. It reads a one-bit comparator decision once per bit period and settles the bits from the most significant to the least significant. The finished word goes into an output holding register, and the active-low busy output then returns high.

The held word reaches the data outputs only while both chip select and read are low. The tri-state bus is modelled as a data word plus an output-enable, and the data word reads zero while it is not enabled. A format input chooses straight binary or two's complement. An active-low power-down input blocks new conversions. After power-down is released, starts are refused for a further wake-up interval. All control inputs are asynchronous and pass through two-flop synchronisers. Reset is synchronous and active high.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion starts only on a falling edge of `convst_n` seen while `cs_n` is low, the block is awake and no conversion is running. `busy_n` goes low on the third clock edge after the input falls.
- R2: Once a conversion is running, further `convst_n` edges have no effect. `busy_n` stays low for exactly SETUP_CYCLES+BITS+2 cycles, which is 15 with the defaults.
- R3: At start the approximation register is cleared and its MSB (bit 11) is set as the first trial on `dac_word`. Bits are then decided one per cycle from bit 11 down to bit 0. A high `cmp_hi` clears the bit under trial and a low `cmp_hi` keeps it.
- R4: `busy_n` is low for the whole conversion and goes high once it completes.
- R5: The new result is in the output register, and visible on an enabled bus, in the last cycle in which `busy_n` is still low.
- R6: During a conversion the output register keeps the previous result, so a read while busy returns the earlier sample.
- R7: `dout_oe` is high only while both `cs_n` and `rd_n` are low, two clocks after the synchronisers. While `dout_oe` is low, `dout` reads all zeros.
- R8: While `shdn_n` is low, a falling `convst_n` starts nothing.
- R9: After `shdn_n` rises, starts are refused for WAKE_CYCLES clock cycles (88 by default, about 350 ns at 250 MHz).
- R10: With `bipolar` low the output is straight binary (raw code). With `bipolar` high, bit 11 of the raw code is inverted to give two's complement. A raw 0x000 then reads 0x800 (most negative) and a raw 0xFFF reads 0x7FF (most positive).
- R11: After reset `busy_n` is high, `dac_word` is zero, the held result is zero and `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| convst_n | input | 1 | Conversion start; the falling edge starts a conversion |
| rd_n | input | 1 | Read enable, active low, asynchronous |
| shdn_n | input | 1 | Power-down, active low, asynchronous |
| bipolar | input | 1 | Output format: 0 straight binary, 1 two's complement |
| cmp_hi | input | 1 | Comparator decision: 1 means the trial word exceeds the input |
| busy_n | output | 1 | Low while a conversion runs |
| dac_word | output | 12 | Trial word to the DAC |
| dout | output | 12 | Output data, zero when not enabled |
| dout_oe | output | 1 | Output-enable of the data bus |

## Verification
The hardest case to reach is a start request that lands while the block refuses it. That covers an edge in the middle of a running conversion and an edge inside the wake-up window just after power-down ends. Neither case shows up at the ports unless the bench times the edges against the busy output and the power-down release. The bench therefore drives an extra start pulse a fixed number of cycles into a conversion and checks that the busy length does not change. It also pulses start a few cycles after leaving power-down and watches that busy stays high. A comparator model that compares the live trial word with a stored input value turns every completed conversion into a known code. Random inputs in both formats fill in the rest.

// File: rtl/sarctl_pkg.sv
package sarctl_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_DECIDE,
        SEQ_LATCH,
        SEQ_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic cs;
        logic convst;
        logic rd;
        logic shdn;
    } ctl_pins_t;

    localparam int unsigned CTL_PIN_COUNT = $bits(ctl_pins_t);

endpackage

// File: rtl/sarctl_sync.sv
module sarctl_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/sarctl_wake.sv
module sarctl_wake #(
    parameter int unsigned WAKE_CYCLES = 88
) (
    input  logic clk,
    input  logic rst,
    input  logic awake,
    output logic ready
);
    localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (!awake) begin
            left_q <= CW'(WAKE_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign ready = awake && (left_q == '0);

    AST_WAKE_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (awake && !$past(awake)) |-> !ready); // R9
endmodule

// File: rtl/sarctl_seq.sv
module sarctl_seq
    import sarctl_pkg::*;
#(
    parameter int unsigned BITS = 12,
    parameter int unsigned SETUP_CYCLES = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            cmp_hi,
    output logic            busy,
    output logic            load,
    output logic [BITS-1:0] trial
);
    localparam int unsigned IW = $clog2(BITS);
    localparam int unsigned SW = $clog2(SETUP_CYCLES + 1);
    localparam logic [BITS-1:0] ONE_W = BITS'(1);
    localparam logic [BITS-1:0] MSB_W = ONE_W << (BITS - 1);

    seq_state_e      state_q;
    logic [IW-1:0]   bit_q;
    logic [SW-1:0]   setup_q;
    logic [BITS-1:0] sar_q;
    logic [BITS-1:0] cur_mask;
    logic [BITS-1:0] sar_nxt;

    always_comb begin
        cur_mask = ONE_W << bit_q;
        sar_nxt  = sar_q;
        if (cmp_hi) begin
            sar_nxt = sar_nxt & ~cur_mask;
        end
        if (bit_q != '0) begin
            sar_nxt = sar_nxt | (cur_mask >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            bit_q   <= '0;
            setup_q <= '0;
            sar_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        sar_q   <= MSB_W;
                        bit_q   <= IW'(BITS - 1);
                        setup_q <= SW'(SETUP_CYCLES - 1);
                        state_q <= SEQ_SETUP;
                    end
                end
                SEQ_SETUP: begin
                    if (setup_q == '0) begin
                        state_q <= SEQ_DECIDE;
                    end else begin
                        setup_q <= setup_q - SW'(1);
                    end
                end
                SEQ_DECIDE: begin
                    sar_q <= sar_nxt;
                    if (bit_q == '0) begin
                        state_q <= SEQ_LATCH;
                    end else begin
                        bit_q <= bit_q - IW'(1);
                    end
                end
                SEQ_LATCH: state_q <= SEQ_DRAIN;
                SEQ_DRAIN: state_q <= SEQ_IDLE;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy  = (state_q != SEQ_IDLE);
    assign load  = (state_q == SEQ_LATCH);
    assign trial = sar_q;

    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && start) |=> (trial == MSB_W)); // R3
    AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_DECIDE && $past(state_q) == SEQ_DECIDE)
            |-> (bit_q == $past(bit_q) - IW'(1))); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_IDLE && state_q != SEQ_SETUP) |=> (state_q != SEQ_SETUP)); // R2
endmodule

// File: rtl/sarctl_out.sv
module sarctl_out #(
    parameter int unsigned BITS = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] raw,
    input  logic            bipolar,
    input  logic            bus_en,
    output logic [BITS-1:0] held,
    output logic [BITS-1:0] dout,
    output logic            oe
);
    logic [BITS-1:0] held_q;
    logic [BITS-1:0] code;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= raw;
        end
    end

    for (genvar i = 0; i < BITS; i++) begin : g_fmt
        if (i == BITS - 1) begin : g_sign
            assign code[i] = held_q[i] ^ bipolar;
        end else begin : g_mag
            assign code[i] = held_q[i];
        end
    end

    assign held = held_q;
    assign dout = bus_en ? code : '0;
    assign oe   = bus_en;

    AST_HOLD_PREV: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held_q)); // R6
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sarctl_pkg::*;
#(
    parameter int unsigned BITS = 12,
    parameter int unsigned SETUP_CYCLES = 1,
    parameter int unsigned WAKE_CYCLES = 88
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            convst_n,
    input  logic            rd_n,
    input  logic            shdn_n,
    input  logic            bipolar,
    input  logic            cmp_hi,
    output logic            busy_n,
    output logic [BITS-1:0] dac_word,
    output logic [BITS-1:0] dout,
    output logic            dout_oe
);
    localparam int unsigned CONV_CYCLES = SETUP_CYCLES + BITS + 2;
    localparam int unsigned LW = $clog2(CONV_CYCLES + 1) + 1;

    ctl_pins_t       pins_raw;
    ctl_pins_t       pins_s;
    logic            convst_prev_q;
    logic            conv_fall;
    logic            wake_ready;
    logic            seq_busy;
    logic            seq_load;
    logic            start;
    logic [BITS-1:0] held_word;

    assign pins_raw = '{cs: cs_n, convst: convst_n, rd: rd_n, shdn: shdn_n};

    sarctl_sync #(.W(CTL_PIN_COUNT), .RST_VAL('1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            convst_prev_q <= 1'b1;
        end else begin
            convst_prev_q <= pins_s.convst;
        end
    end

    assign conv_fall = convst_prev_q && !pins_s.convst;

    sarctl_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk   (clk),
        .rst   (rst),
        .awake (pins_s.shdn),
        .ready (wake_ready)
    );

    assign start = conv_fall && !pins_s.cs && wake_ready && !seq_busy;

    sarctl_seq #(.BITS(BITS), .SETUP_CYCLES(SETUP_CYCLES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cmp_hi (cmp_hi),
        .busy   (seq_busy),
        .load   (seq_load),
        .trial  (dac_word)
    );

    sarctl_out #(.BITS(BITS)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (seq_load),
        .raw     (dac_word),
        .bipolar (bipolar),
        .bus_en  (!pins_s.cs && !pins_s.rd),
        .held    (held_word),
        .dout    (dout),
        .oe      (dout_oe)
    );

    assign busy_n = !seq_busy;

    logic [LW-1:0] busy_len_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len_q <= '0;
        end else if (seq_busy) begin
            busy_len_q <= busy_len_q + LW'(1);
        end else begin
            busy_len_q <= '0;
        end
    end

    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> $past(!pins_s.cs && pins_s.shdn)); // R1
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> (busy_len_q == LW'(CONV_CYCLES))); // R2
    AST_READY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> ($stable(held_word) && held_word == dac_word)); // R5
    AST_SHDN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        !pins_s.shdn |=> !$fell(busy_n)); // R8
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0)); // R7
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        convst_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        shdn_n = 1'b1;
    logic        bipolar = 1'b0;
    logic        cmp_hi;
    logic        busy_n;
    logic [11:0] dac_word;
    logic [11:0] dout;
    logic        dout_oe;
    logic [11:0] vin = 12'h000;
    logic [11:0] last_raw = 12'h000;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    // comparator model: trial above the input clears the bit
    assign cmp_hi = (dac_word > vin);

    sar_adc_ctrl uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .convst_n(convst_n), .rd_n(rd_n),
        .shdn_n(shdn_n), .bipolar(bipolar), .cmp_hi(cmp_hi), .busy_n(busy_n),
        .dac_word(dac_word), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [11:0] fmt(input logic [11:0] raw, input logic bip);
        return bip ? (raw ^ 12'h800) : raw;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_conv(input logic [11:0] v, input logic bip, input bit extra);
        int k;
        int n;
        logic [11:0] first_d;
        logic [11:0] last_d;
        vin = v;
        bipolar = bip;
        convst_n = 1'b0;
        k = 0;
        while (busy_n !== 1'b0 && k < 10) begin
            @(negedge clk);
            k++;
            if (k == 2) convst_n = 1'b1;
        end
        convst_n = 1'b1;
        chk(k == 3, "R1 start latency", k, 3);
        first_d = dout;
        chk(first_d == fmt(last_raw, bip), "R6 old result while busy", first_d, fmt(last_raw, bip));
        n = 1;
        last_d = first_d;
        while (n < 100) begin
            @(negedge clk);
            if (busy_n !== 1'b0) break;
            n++;
            last_d = dout;
            if (extra && n == 4) convst_n = 1'b0;
            if (extra && n == 6) convst_n = 1'b1;
        end
        chk(n == 15, extra ? "R2 busy length with extra start" : "R4 busy length", n, 15);
        chk(last_d == fmt(v, bip), "R5 data before busy rise", last_d, fmt(v, bip));
        chk(dout == fmt(v, bip), bip ? "R10 bipolar code" : "R3 conversion result", dout, fmt(v, bip));
        last_raw = v;
        wait_neg(2);
    endtask

    task automatic expect_no_start(input string req);
        int lows;
        lows = 0;
        convst_n = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (i == 2) convst_n = 1'b1;
            if (busy_n !== 1'b1) lows++;
        end
        convst_n = 1'b1;
        chk(lows == 0, req, lows, 0);
    endtask

    initial begin
        void'($urandom(32'h1d5a7c3));
        wait_neg(4);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_n === 1'b1, "R11 busy after reset", busy_n, 1);
        chk(dout_oe === 1'b0, "R11 bus disabled after reset", dout_oe, 0);
        chk(dac_word === 12'h000, "R11 trial word after reset", dac_word, 0);
        cs_n = 1'b0;
        rd_n = 1'b0;
        wait_neg(3);
        chk(dout === 12'h000, "R11 held result after reset", dout, 0);

        // directed conversions
        run_conv(12'hA5C, 1'b0, 1'b0);
        run_conv(12'h000, 1'b0, 1'b0);
        run_conv(12'hFFF, 1'b0, 1'b0);
        run_conv(12'h3C1, 1'b0, 1'b1);
        run_conv(12'h000, 1'b1, 1'b0);
        run_conv(12'hFFF, 1'b1, 1'b0);
        run_conv(12'h800, 1'b1, 1'b0);
        chk(dout == 12'h000, "R10 bipolar mid-scale", dout, 0);
        bipolar = 1'b0;
        @(negedge clk);
        chk(dout == 12'h800, "R10 unipolar mid-scale", dout, 12'h800);

        // bus enable decode
        rd_n = 1'b1;
        wait_neg(3);
        chk(dout_oe == 1'b0 && dout == 12'h000, "R7 rd high", {dout_oe, dout}, 0);
        rd_n = 1'b0;
        cs_n = 1'b1;
        wait_neg(3);
        chk(dout_oe == 1'b0 && dout == 12'h000, "R7 cs high", {dout_oe, dout}, 0);

        // start with chip select high is ignored
        expect_no_start("R1 start refused with cs high");
        cs_n = 1'b0;
        wait_neg(3);
        chk(dout_oe == 1'b1 && dout == 12'h800, "R7 enabled, result kept after refused start",
            {dout_oe, dout}, {1'b1, 12'h800});

        // power-down and wake-up window
        vin = 12'h123;
        shdn_n = 1'b0;
        wait_neg(4);
        expect_no_start("R8 start refused in power-down");
        chk(dout == 12'h800, "R8 result unchanged after power-down start", dout, 12'h800);
        shdn_n = 1'b1;
        wait_neg(6);
        expect_no_start("R9 start refused during wake-up");
        chk(dout == 12'h800, "R9 result unchanged after early start", dout, 12'h800);
        wait_neg(100);
        run_conv(12'h123, 1'b0, 1'b0);

        // random conversions
        for (int r = 0; r < 40; r++) begin
            logic [11:0] v;
            logic b;
            v = 12'($urandom % 4096);
            if (v == last_raw) v = v ^ 12'h001;
            b = 1'($urandom % 2);
            run_conv(v, b, (r % 7) == 3);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule